// File: doc/BRIEF.md
# I2C Configuration Register Bank

This block is an I2C target that holds a small bank of configuration bytes for a mixed-signal switch. A fast system clock oversamples the bus lines. The block recognises START and STOP conditions and answers one fixed 7-bit device address. Written bytes carry no register index. They always fill the bank from the first register upward. A read returns a single identification byte. The register contents leave the block as one flat parallel bus, and a single output enables an external open-drain pull-down on the data line.

A general-call address followed by a fixed command byte restores every register to its power-up value. Any other traffic is left alone: a foreign address, an unknown general-call command, or bytes clocked while no transfer is active. The system clock must run at least sixteen times faster than the 400 kHz bus.

Top module: `i2c_cfg_bank`

## Requirements
- R1: After reset, register 0 holds 0x80 (its MSB is the mute bit, set) and registers 1 to 4 hold 0x00. `cfg_o` packs register k into bits [8k+7:8k], and `sda_oe` is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP, `sda_oe` is 0 and bytes clocked without a new START are neither acknowledged nor stored.
- R3: The first byte after START is a 7-bit address, MSB first, followed by a direction bit (1 = read, 0 = write). For address 1001000, `sda_oe` goes to 1 after the SCL falling edge that ends the eighth bit. It returns to 0 after the SCL falling edge that ends the ninth clock.
- R4: An address byte that is neither 1001000x nor 0x00 gets no acknowledge, and the block ignores the bus until the next START.
- R5: On a write, the first data byte goes to register 0 and each later byte goes to the next register. Every data byte is acknowledged, and registers that were not reached keep their values.
- R6: Data bytes past register 4 are acknowledged and discarded.
- R7: A read returns 0x10 MSB first: the upper nibble is the ID 0001 and the lower nibble is 0000. `sda_oe` equals the inverse of each bit from the SCL falling edge before that bit. The block releases the line after the eighth bit, and after the master's acknowledge clock it stays idle.
- R8: Address 0x00 followed by data 0x06 is acknowledged on both bytes, and all registers return to their R1 values.
- R9: Address 0x00 followed by any data byte other than 0x06 leaves the second byte unacknowledged and the registers unchanged.
- R10: A repeated START during a write sets the register index back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 = pull the data line low |
| cfg_o | output | NUM_REGS*8 | Register bank, register k at bits [8k+7:8k] |

## Verification
The hardest situations to reach are those where the bus must be observed doing nothing. Examples are the unacknowledged second byte of a general call, a foreign address followed by more clocked data, and a byte clocked after a STOP with no new START. The stimulus drives complete wired-AND transactions of exactly those shapes. A behavioural model of the register index and transfer state then confirms, on every system clock, that neither the data-line drive nor any register byte moved. A repeated START placed midway through a write proves that the index restarts while register 1 keeps its earlier byte.

// File: rtl/i2c_cfg_pkg.sv
`timescale 1ns/1ps
package i2c_cfg_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = 4;

    localparam logic [BYTE_W-1:0] GCALL_ADDR_BYTE = 8'h00;
    localparam logic [BYTE_W-1:0] GCALL_RESET_CMD = 8'h06;
    localparam logic [BYTE_W-1:0] MUTE_DEFAULT    = 8'h80;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACK,
        PH_SEND,
        PH_MACK
    } phase_e;

    typedef enum logic [1:0] {
        MD_ADDR,
        MD_WRITE,
        MD_READ,
        MD_GCALL
    } mode_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic  ack;
        logic  write;
        logic  wipe;
        mode_e next_mode;
    } byte_verdict_t;

    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        return (idx == 0) ? MUTE_DEFAULT : '0;
    endfunction

    function automatic logic addr_match(input logic [BYTE_W-1:0] b,
                                        input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic logic [BYTE_W-1:0] id_byte(input logic [3:0] id);
        return {id, 4'b0000};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync
    import i2c_cfg_pkg::*;
#(
    parameter int STAGES = 2
)(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    // STAGES synchroniser flops plus one history flop per line
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[STAGES-1];
    assign scl_old = scl_pipe[STAGES];
    assign sda_now = sda_pipe[STAGES-1];
    assign sda_old = sda_pipe[STAGES];

    always_comb begin
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
    end

endmodule

// File: rtl/i2c_byte_engine.sv
`timescale 1ns/1ps
module i2c_byte_engine
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS  = 5,
    parameter int         PTR_W     = 3,
    parameter logic [6:0] DEV_ADDR  = 7'h48,
    parameter logic [3:0] ID_NIBBLE = 4'h1
)(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wipe
);
    localparam logic [BYTE_W-1:0]    ID_BYTE  = id_byte(ID_NIBBLE);
    localparam logic [PTR_W-1:0]     PTR_END  = PTR_W'(NUM_REGS);
    localparam logic [BIT_CNT_W-1:0] FULL_CNT = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_TX  = BIT_CNT_W'(BYTE_W - 1);

    phase_e              phase;
    mode_e               mode;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [PTR_W-1:0]    ptr;
    logic                byte_done;
    byte_verdict_t       vd;

    // A received byte is complete on the SCL fall that ends its eighth bit
    assign byte_done = (phase == PH_RECV) && ev.scl_fall && (bit_cnt == FULL_CNT);

    always_comb begin
        vd.ack       = 1'b0;
        vd.write     = 1'b0;
        vd.wipe      = 1'b0;
        vd.next_mode = mode;
        unique case (mode)
            MD_ADDR: begin
                if (addr_match(rx_sh, DEV_ADDR)) begin
                    vd.ack       = 1'b1;
                    vd.next_mode = rx_sh[0] ? MD_READ : MD_WRITE;
                end else if (rx_sh == GCALL_ADDR_BYTE) begin
                    vd.ack       = 1'b1;
                    vd.next_mode = MD_GCALL;
                end
            end
            MD_WRITE: begin
                vd.ack   = 1'b1;
                vd.write = (ptr != PTR_END);
            end
            MD_GCALL: begin
                if (rx_sh == GCALL_RESET_CMD) begin
                    vd.ack  = 1'b1;
                    vd.wipe = 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign wr_en   = byte_done & vd.write;
    assign wr_idx  = ptr;
    assign wr_data = rx_sh;
    assign wipe    = byte_done & vd.wipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            mode    <= MD_ADDR;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.start) begin
            phase   <= PH_RECV;
            mode    <= MD_ADDR;
            bit_cnt <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else begin
            unique case (phase)
                PH_RECV: begin
                    if (ev.scl_rise && bit_cnt != FULL_CNT) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], ev.sda};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_done) begin
                        if (vd.ack) begin
                            sda_oe <= 1'b1;
                            phase  <= PH_ACK;
                            mode   <= vd.next_mode;
                            if (vd.write) ptr <= ptr + 1'b1;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                end
                PH_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (mode == MD_READ) begin
                            phase  <= PH_SEND;
                            tx_sh  <= ID_BYTE;
                            sda_oe <= ~ID_BYTE[BYTE_W-1];
                        end else begin
                            phase  <= PH_RECV;
                            sda_oe <= 1'b0;
                        end
                    end
                end
                PH_SEND: begin
                    if (ev.scl_fall) begin
                        if (bit_cnt == LAST_TX) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_MACK;
                        end else begin
                            sda_oe  <= ~tx_sh[BYTE_W-2];
                            tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                PH_MACK: begin
                    if (ev.scl_fall) phase <= PH_IDLE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfg_reg_file.sv
`timescale 1ns/1ps
module cfg_reg_file
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int PTR_W    = 3
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       wipe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || wipe)
                q <= reg_default(g);
            else if (wr_en && wr_idx == PTR_W'(g))
                q <= wr_data;
        end
        assign cfg_o[g*BYTE_W +: BYTE_W] = q;
    end

endmodule

// File: rtl/i2c_cfg_bank.sv
`timescale 1ns/1ps
module i2c_cfg_bank
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 5,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter logic [3:0] ID_NIBBLE   = 4'h1
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    bus_ev_t           ev;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic              wipe;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_byte_engine #(
        .NUM_REGS  (NUM_REGS),
        .PTR_W     (PTR_W),
        .DEV_ADDR  (DEV_ADDR),
        .ID_NIBBLE (ID_NIBBLE)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wipe    (wipe)
    );

    cfg_reg_file #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wipe    (wipe),
        .cfg_o   (cfg_o)
    );

endmodule

// File: rtl/i2c_cfg_bank_checker.sv
`timescale 1ns/1ps
module i2c_cfg_bank_checker
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS    = 5,
    parameter int SYNC_STAGES = 2
)(
    input logic                       clk,
    input logic                       rst,
    input logic                       scl_i,
    input logic                       sda_i,
    input logic                       sda_oe,
    input logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    logic [SYNC_STAGES:0] scl_h, sda_h;
    always_ff @(posedge clk) begin
        if (rst) begin
            scl_h <= '1;
            sda_h <= '1;
        end else begin
            scl_h <= {scl_h[SYNC_STAGES-1:0], scl_i};
            sda_h <= {sda_h[SYNC_STAGES-1:0], sda_i};
        end
    end

    logic s_hi, s_fall, s_stop, s_start;
    assign s_hi    = scl_h[SYNC_STAGES-1] & scl_h[SYNC_STAGES];
    assign s_fall  = ~scl_h[SYNC_STAGES-1] & scl_h[SYNC_STAGES];
    assign s_stop  = s_hi & ~sda_h[SYNC_STAGES] & sda_h[SYNC_STAGES-1];
    assign s_start = s_hi & sda_h[SYNC_STAGES] & ~sda_h[SYNC_STAGES-1];

    logic [NUM_REGS*BYTE_W-1:0] dflt;
    always_comb begin
        for (int k = 0; k < NUM_REGS; k++)
            dflt[k*BYTE_W +: BYTE_W] = reg_default(k);
    end

    logic was_rst;
    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (was_rst && !rst) begin
            a_r1_defaults_after_reset: assert (cfg_o == dflt && !sda_oe)
                else $error("register bank not at defaults after reset");
        end
    end

    // R3 / R7: the data-line drive moves only after an SCL fall or a bus condition
    a_r3_oe_moves_on_scl_fall: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(rst)) |-> ($past(s_fall) || $past(s_start) || $past(s_stop)));

    // R5 / R8: registers change only at the SCL fall that completes a byte
    a_r5_cfg_moves_on_scl_fall: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cfg_o) && !$past(rst)) |-> $past(s_fall));

    // R2: a STOP always leaves the line released
    a_r2_release_after_stop: assert property (@(posedge clk) disable iff (rst)
        s_stop |=> !sda_oe);

    // R7: the drive is steady while SCL stays high
    a_r7_oe_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
        (s_hi && !s_start && !s_stop) |=> $stable(sda_oe));

endmodule

bind i2c_cfg_bank i2c_cfg_bank_checker #(
    .NUM_REGS    (NUM_REGS),
    .SYNC_STAGES (SYNC_STAGES)
) u_checker (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .sda_oe (sda_oe),
    .cfg_o  (cfg_o)
);

// File: tb/i2c_cfg_bank_test.sv
`timescale 1ns/1ps
module i2c_cfg_bank_test;
    localparam int NR     = 5;
    localparam int HALF   = 10;
    localparam int SETTLE = 6;
    localparam logic [7:0] ID_EXP = 8'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NR*8-1:0] cfg;
    logic sda_bus;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_cfg_bank #(.NUM_REGS(NR)) uut (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .cfg_o  (cfg)
    );

    always #2.5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int settle = 0;
    bit live = 1'b0;
    bit done = 1'b0;
    string req = "R1";

    // behavioural reference: register bytes, index, transfer state
    logic [7:0] ref_reg [NR];
    logic ref_oe = 1'b0;
    int ref_ptr = 0;
    int ref_st = 0;   // 0 idle, 1 address, 2 write, 3 general call, 4 read

    function automatic logic [NR*8-1:0] ref_bus();
        logic [NR*8-1:0] v;
        for (int k = 0; k < NR; k++) v[k*8 +: 8] = ref_reg[k];
        return v;
    endfunction

    function void ref_defaults();
        for (int k = 0; k < NR; k++) ref_reg[k] = (k == 0) ? 8'h80 : 8'h00;
    endfunction

    function bit ref_byte(input logic [7:0] b);
        case (ref_st)
            1: begin
                if (b[7:1] == 7'b1001000) begin
                    ref_st = b[0] ? 4 : 2;
                    return 1'b1;
                end else if (b == 8'h00) begin
                    ref_st = 3;
                    return 1'b1;
                end
                ref_st = 0;
                return 1'b0;
            end
            2: begin
                if (ref_ptr < NR) ref_reg[ref_ptr] = b;
                ref_ptr++;
                return 1'b1;
            end
            3: begin
                if (b == 8'h06) begin
                    ref_defaults();
                    return 1'b1;
                end
                ref_st = 0;
                return 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

    task automatic note(input bit ok, input string r, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (settle > 0) settle--;
        else if (live) begin
            note(cfg == ref_bus(), req, "cfg_o per clock", 64'(cfg), 64'(ref_bus()));
            note(sda_oe == ref_oe, req, "sda_oe per clock", 64'(sda_oe), 64'(ref_oe));
        end
    endtask

    task automatic set_scl(input logic v);
        scl = v;
        settle = SETTLE;
        repeat (HALF) tick();
    endtask

    task automatic set_sda(input logic v);
        sda_m = v;
        settle = SETTLE;
        repeat (HALF) tick();
    endtask

    task automatic bus_start();
        set_sda(1'b1);
        set_scl(1'b1);
        set_sda(1'b0);
        ref_st = 1;
        ref_ptr = 0;
        set_scl(1'b0);
    endtask

    task automatic bus_stop();
        set_sda(1'b0);
        set_scl(1'b1);
        set_sda(1'b1);
        ref_st = 0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit want;
        want = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            set_sda(b[i]);
            set_scl(1'b1);
            if (i == 0) begin
                want = ref_byte(b);
                ref_oe = want;
            end
            set_scl(1'b0);
        end
        set_sda(1'b1);
        set_scl(1'b1);
        acked = ~sda_bus;
        note(acked == want, req, "acknowledge", 64'(acked), 64'(want));
        ref_oe = (want && ref_st == 4) ? ~ID_EXP[7] : 1'b0;
        set_scl(1'b0);
    endtask

    task automatic read_byte(output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            set_scl(1'b1);
            got[i] = sda_bus;
            ref_oe = (i > 0) ? ~ID_EXP[i-1] : 1'b0;
            set_scl(1'b0);
        end
        set_sda(1'b0);
        set_scl(1'b1);
        ref_st = 0;
        set_scl(1'b0);
        set_sda(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL %s watchdog: actual %0d expected %0d", req, 200000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        bit a;
        logic [7:0] got;
        repeat (10) tick();
        rst = 1'b0;
        repeat (4) tick();

        // R1: reset contents
        note(cfg == 40'h00_0000_0080, "R1", "reset cfg", 64'(cfg), 64'h80);
        note(sda_oe == 1'b0, "R1", "reset sda_oe", 64'(sda_oe), 64'h0);
        ref_defaults();
        live = 1'b1;

        // R3: address acknowledge window, then R5 single write
        req = "R3";
        bus_start();
        send_byte(8'h90, a);
        note(a == 1'b1, "R3", "address ack", 64'(a), 64'h1);
        req = "R5";
        send_byte(8'hA5, a);
        bus_stop();
        note(cfg[7:0] == 8'hA5, "R5", "reg0 after one byte", 64'(cfg[7:0]), 64'hA5);
        note(cfg[39:8] == 32'h0, "R5", "untouched regs", 64'(cfg[39:8]), 64'h0);

        // R5: full sequence
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        send_byte(8'h44, a);
        send_byte(8'h55, a);
        bus_stop();
        note(cfg == 40'h55_44_33_22_11, "R5", "five bytes in order", 64'(cfg), 64'h5544332211);

        // R6: overflow bytes acknowledged and dropped
        req = "R6";
        bus_start();
        send_byte(8'h90, a);
        for (int k = 1; k <= 7; k++) send_byte(8'(k), a);
        note(a == 1'b1, "R6", "ack of seventh byte", 64'(a), 64'h1);
        bus_stop();
        note(cfg == 40'h05_04_03_02_01, "R6", "overflow discarded", 64'(cfg), 64'h0504030201);

        // R10: repeated START restarts the index
        req = "R10";
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'hC1, a);
        send_byte(8'hC2, a);
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'hD1, a);
        bus_stop();
        note(cfg[15:0] == 16'hC2D1, "R10", "index restarted", 64'(cfg[15:0]), 64'hC2D1);

        // R4: foreign address ignored
        req = "R4";
        bus_start();
        send_byte(8'h92, a);
        note(a == 1'b0, "R4", "foreign address nak", 64'(a), 64'h0);
        send_byte(8'h77, a);
        note(a == 1'b0, "R4", "following byte nak", 64'(a), 64'h0);
        bus_stop();
        note(cfg == 40'h05_04_03_C2_D1, "R4", "cfg unchanged", 64'(cfg), 64'h050403C2D1);

        // R7: read the ID byte
        req = "R7";
        bus_start();
        send_byte(8'h91, a);
        note(a == 1'b1, "R7", "read address ack", 64'(a), 64'h1);
        read_byte(got);
        note(got == ID_EXP, "R7", "read byte", 64'(got), 64'(ID_EXP));
        note(sda_oe == 1'b0, "R7", "line released", 64'(sda_oe), 64'h0);
        bus_stop();

        // R9: general call with an unknown command
        req = "R9";
        bus_start();
        send_byte(8'h00, a);
        note(a == 1'b1, "R9", "general call ack", 64'(a), 64'h1);
        send_byte(8'h05, a);
        note(a == 1'b0, "R9", "unknown command nak", 64'(a), 64'h0);
        bus_stop();
        note(cfg == 40'h05_04_03_C2_D1, "R9", "cfg unchanged", 64'(cfg), 64'h050403C2D1);

        // R8: general call reset
        req = "R8";
        bus_start();
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        note(a == 1'b1, "R8", "reset command ack", 64'(a), 64'h1);
        bus_stop();
        note(cfg == 40'h00_0000_0080, "R8", "defaults restored", 64'(cfg), 64'h80);

        // R2: bytes after a STOP without a new START are ignored
        req = "R2";
        bus_start();
        send_byte(8'h90, a);
        send_byte(8'hEE, a);
        bus_stop();
        set_scl(1'b0);
        send_byte(8'h33, a);
        note(a == 1'b0, "R2", "no ack without START", 64'(a), 64'h0);
        note(cfg[15:8] == 8'h00, "R2", "reg1 untouched", 64'(cfg[15:8]), 64'h0);
        bus_stop();
        note(cfg[7:0] == 8'hEE, "R2", "reg0 from framed write", 64'(cfg[7:0]), 64'hEE);

        repeat (20) tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule